// File: doc/BRIEF.md
# Truncating Float-to-Integer Converter

This block turns a floating-point operand that has already been unpacked into fields into a signed two's-complement integer of `INT_W` bits (32 by default). The operand arrives as a three-bit class code, a sign bit, a signed unbiased exponent and a normalised mantissa whose leading one is explicit in its top bit. The magnitude is the integer part of `mant * 2^(exp - (MANT_W-1))`. The conversion always truncates toward zero. The fraction bits that fall off are never used for rounding. They only raise the inexact flag.

Values that do not fit saturate to the largest integer with the operand's sign. Infinities and NaNs saturate in the same way. Saturation raises the invalid flag and suppresses inexact. The range test is not symmetric: a negative operand may reach exactly -2^(INT_W-1), but a positive operand of that magnitude saturates. Inside, a log-stage right shifter gathers every bit shifted out into a sticky bit. Any shift count at or beyond the mantissa width clears the shifted value. Results are registered and qualified by a valid strobe that follows the input strobe by one cycle.

Top module: `fti_trunc_conv`

## Requirements
- R1: An operand with class code 0 (zero) produces integer 0 with inexact and invalid both clear, whatever its sign, exponent and mantissa.
- R2: An operand with class code 1 (number) whose signed exponent is `INT_W` or more is an overflow.
- R3: For a class-1 operand that does not overflow, the result is m for sign 0 and the two's complement of m for sign 1. Here m is the mantissa shifted right by `MANT_W-1-exp` places and truncated, so a negative exponent gives m = 0.
- R4: For a class-1 operand that does not overflow, inexact is set exactly when at least one mantissa bit shifted out by the R3 shift is 1, and invalid is clear. A shift of `MANT_W` or more moves every mantissa bit into the sticky bit.
- R5: A class-1 operand overflows when m >= 2^(INT_W-1) + sign. A magnitude of exactly 2^(INT_W-1) is therefore accepted for sign 1, giving 0x80000000, and saturates for sign 0.
- R6: Class codes 2 (infinity), 3 (quiet NaN), 4 (signalling NaN) and the unused codes 5 to 7 are always treated as overflow.
- R7: On overflow the result is 0x7FFFFFFF when the sign is 0 and 0x80000000 when the sign is 1, invalid is set and inexact is clear.
- R8: The result and flags for an operand presented with `in_valid` high appear one clock later with `out_valid` high. In a cycle after `in_valid` was low, `out_valid` is low and the result and flags keep their values. Reset clears `out_valid`, the result and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand strobe |
| in_class | input | 3 | Class code: 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| in_sign | input | 1 | Operand sign, 1 = negative |
| in_exp | input | EXP_W | Signed unbiased exponent |
| in_mant | input | MANT_W | Mantissa, leading one at bit MANT_W-1 |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_int | output | INT_W | Signed integer result |
| out_inexact | output | 1 | Nonzero fraction bits were discarded |
| out_invalid | output | 1 | Operand saturated (out of range, infinity or NaN) |

## Verification
The bench builds the block with its default parameters: a 64-bit mantissa, a 12-bit exponent and a 32-bit result. The 12-bit exponent reaches -2048, so the shifter is driven far past its saturation point, and it also reaches values well beyond the overflow threshold of 32. With a 64-bit mantissa, exponent 31 leaves 32 fraction bits, so operands just below and just at the 2^31 boundary can carry or lack discarded bits. That lets the asymmetric limit of R5 be combined with and without inexact. Random operands mix all eight class codes and sometimes clear the low mantissa bits, so exact and inexact conversions both occur. Directed cases cover the exponent edges -1, 0, 31 and 32.

// File: rtl/fti_pkg.sv
package fti_pkg;

  typedef enum logic [2:0] {
    FCLS_ZERO = 3'd0,
    FCLS_NUM  = 3'd1,
    FCLS_INF  = 3'd2,
    FCLS_QNAN = 3'd3,
    FCLS_SNAN = 3'd4
  } fcls_e;

  function automatic logic cls_is_zero(input logic [2:0] c);
    return c == FCLS_ZERO;
  endfunction

  function automatic logic cls_is_num(input logic [2:0] c);
    return c == FCLS_NUM;
  endfunction

endpackage

// File: rtl/fti_sticky_shr.sv
module fti_sticky_shr #(
  parameter int W  = 64,
  parameter int CW = 7
) (
  input  logic [W-1:0]  din,
  input  logic [CW-1:0] cnt,
  output logic [W-1:0]  dout,
  output logic          sticky
);

  logic [W-1:0] stg [CW+1];
  logic         stk [CW+1];

  assign stg[0] = din;
  assign stk[0] = 1'b0;

  for (genvar k = 0; k < CW; k++) begin : g_stage
    localparam int SH = 1 << k;
    if (SH >= W) begin : g_flush
      assign stg[k+1] = cnt[k] ? '0 : stg[k];
      assign stk[k+1] = stk[k] | (cnt[k] & (|stg[k]));
    end else begin : g_part
      assign stg[k+1] = cnt[k] ? (stg[k] >> SH) : stg[k];
      assign stk[k+1] = stk[k] | (cnt[k] & (|stg[k][SH-1:0]));
    end
  end

  assign dout   = stg[CW];
  assign sticky = stk[CW];

endmodule

// File: rtl/fti_range_pack.sv
module fti_range_pack #(
  parameter int INT_W = 32
) (
  input  logic             is_zero,
  input  logic             is_num,
  input  logic             exp_big,
  input  logic             hi_clear,
  input  logic             sign,
  input  logic [INT_W-1:0] mag,
  input  logic             sticky,
  output logic             ovf,
  output logic             nx,
  output logic [INT_W-1:0] value
);

  function automatic logic past_limit(input logic [INT_W-1:0] m, input logic s);
    logic [INT_W:0] lim;
    lim = {2'b01, {(INT_W-1){1'b0}}} + {{INT_W{1'b0}}, s};
    return {1'b0, m} >= lim;
  endfunction

  function automatic logic [INT_W-1:0] sat_code(input logic s);
    return {s, {(INT_W-1){~s}}};
  endfunction

  function automatic logic [INT_W-1:0] apply_sign(input logic [INT_W-1:0] m, input logic s);
    return s ? (~m + 1'b1) : m;
  endfunction

  always_comb begin
    ovf   = !is_zero && (!is_num || exp_big || !hi_clear || past_limit(mag, sign));
    nx    = is_num && !ovf && sticky;
    if (is_zero)  value = '0;
    else if (ovf) value = sat_code(sign);
    else          value = apply_sign(mag, sign);
  end

endmodule

// File: rtl/fti_trunc_conv.sv
module fti_trunc_conv #(
  parameter int MANT_W = 64,
  parameter int EXP_W  = 12,
  parameter int INT_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [2:0]              in_class,
  input  logic                    in_sign,
  input  logic signed [EXP_W-1:0] in_exp,
  input  logic [MANT_W-1:0]       in_mant,
  output logic                    out_valid,
  output logic [INT_W-1:0]        out_int,
  output logic                    out_inexact,
  output logic                    out_invalid
);
  import fti_pkg::*;

  localparam int CW  = $clog2(MANT_W) + 1;
  localparam int SHW = EXP_W + CW + 1;

  logic signed [SHW-1:0] exp_ext;
  logic signed [SHW-1:0] sh_full;
  logic [CW-1:0]         shift_cnt;
  logic [MANT_W-1:0]     shr_mag;
  logic                  shr_sticky;
  logic                  mag_hi_zero;
  logic                  exp_big;
  logic                  ovf_evt;
  logic                  nx_evt;
  logic [INT_W-1:0]      res_next;

  assign exp_ext = in_exp;
  assign sh_full = SHW'(MANT_W - 1) - exp_ext;

  always_comb begin
    if (sh_full < 0)            shift_cnt = '0;
    else if (sh_full >= MANT_W) shift_cnt = CW'(MANT_W);
    else                        shift_cnt = sh_full[CW-1:0];
  end

  fti_sticky_shr #(.W(MANT_W), .CW(CW)) shr_i (
    .din    (in_mant),
    .cnt    (shift_cnt),
    .dout   (shr_mag),
    .sticky (shr_sticky)
  );

  assign mag_hi_zero = ~|shr_mag[MANT_W-1:INT_W];
  assign exp_big     = in_exp >= INT_W;

  fti_range_pack #(.INT_W(INT_W)) pack_i (
    .is_zero  (cls_is_zero(in_class)),
    .is_num   (cls_is_num(in_class)),
    .exp_big  (exp_big),
    .hi_clear (mag_hi_zero),
    .sign     (in_sign),
    .mag      (shr_mag[INT_W-1:0]),
    .sticky   (shr_sticky),
    .ovf      (ovf_evt),
    .nx       (nx_evt),
    .value    (res_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_int     <= '0;
      out_inexact <= 1'b0;
      out_invalid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_int     <= res_next;
        out_inexact <= nx_evt;
        out_invalid <= ovf_evt;
      end
    end
  end

endmodule

// File: rtl/fti_trunc_conv_chk.sv
module fti_trunc_conv_chk #(
  parameter int MANT_W = 64,
  parameter int EXP_W  = 12,
  parameter int INT_W  = 32,
  parameter int CW     = 7
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [2:0]              in_class,
  input logic                    in_sign,
  input logic signed [EXP_W-1:0] in_exp,
  input logic                    out_valid,
  input logic [INT_W-1:0]        out_int,
  input logic                    out_inexact,
  input logic                    out_invalid,
  input logic [CW-1:0]           shift_cnt,
  input logic [MANT_W-1:0]       shr_mag,
  input logic                    ovf_evt
);

  assert_zero_class_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_class == 3'd0 |=> out_int == '0 && !out_inexact && !out_invalid);

  assert_big_exp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_class == 3'd1 && in_exp >= INT_W |=> out_invalid);

  assert_sign_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_invalid && out_int != '0 |-> out_int[INT_W-1] == $past(in_sign));

  assert_shift_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_cnt >= MANT_W |-> shr_mag == '0);

  assert_special_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_class != 3'd0 && in_class != 3'd1 |=> out_invalid);

  assert_sat_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_invalid |->
      !out_inexact && out_int == {$past(in_sign), {(INT_W-1){!$past(in_sign)}}});

  assert_ovf_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ovf_evt |=> out_invalid);

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_int) && $stable(out_invalid));

endmodule

bind fti_trunc_conv fti_trunc_conv_chk #(
  .MANT_W(MANT_W), .EXP_W(EXP_W), .INT_W(INT_W), .CW(CW)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_class    (in_class),
  .in_sign     (in_sign),
  .in_exp      (in_exp),
  .out_valid   (out_valid),
  .out_int     (out_int),
  .out_inexact (out_inexact),
  .out_invalid (out_invalid),
  .shift_cnt   (shift_cnt),
  .shr_mag     (shr_mag),
  .ovf_evt     (ovf_evt)
);

// File: tb/fti_trunc_conv_tb.sv
`timescale 1ns/1ps
module fti_trunc_conv_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  in_class = 3'd0;
  logic        in_sign = 1'b0;
  logic signed [11:0] in_exp = '0;
  logic [63:0] in_mant = '0;
  logic        out_valid;
  logic [31:0] out_int;
  logic        out_inexact;
  logic        out_invalid;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  fti_trunc_conv #(.MANT_W(64), .EXP_W(12), .INT_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant),
    .out_valid(out_valid), .out_int(out_int),
    .out_inexact(out_inexact), .out_invalid(out_invalid)
  );

  // Reference: restates the requirements on 64-bit magnitudes.
  function automatic void ref_conv(input logic [2:0] c, input logic s, input int e,
                                   input logic [63:0] mt, output logic [31:0] r,
                                   output logic nx, output logic nv, output string tag);
    logic [63:0] m64;
    logic        big;
    int          sh;
    m64 = '0; nx = 1'b0; nv = 1'b0; r = '0;
    if (c == 3'd0) begin tag = "R1"; return; end
    if (c != 3'd1) begin tag = "R6"; big = 1'b1; end
    else if (e >= 32) begin tag = "R2"; big = 1'b1; end
    else begin
      tag = "R3";
      if (e < 0) begin m64 = '0; nx = (mt != 0); tag = "R4"; end
      else begin
        sh  = 63 - e;
        m64 = mt >> sh;
        nx  = ((mt << (64 - sh)) != 0);
      end
      big = (m64 >= (64'h8000_0000 + {63'd0, s}));
      if (big) tag = "R5";
    end
    if (big) begin
      r  = s ? 32'h8000_0000 : 32'h7FFF_FFFF;
      nx = 1'b0;
      nv = 1'b1;
    end else begin
      r = s ? (32'd0 - m64[31:0]) : m64[31:0];
    end
  endfunction

  task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got int=%h nx=%b nv=%b, expected int=%h nx=%b nv=%b",
               tag, act[33:2], act[1], act[0], exp[33:2], exp[1], exp[0]);
    end
  endtask

  task automatic apply(input logic [2:0] c, input logic s, input int e, input logic [63:0] mt);
    logic [31:0] r;
    logic nx, nv;
    string tag;
    ref_conv(c, s, e, mt, r, nx, nv, tag);
    @(negedge clk);
    in_valid = 1'b1; in_class = c; in_sign = s; in_exp = e[11:0]; in_mant = mt;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, {out_int, out_inexact, out_invalid}, {r, nx, nv});
    check("R8", {32'd0, 1'b0, out_valid}, {32'd0, 1'b0, 1'b1});
  endtask

  initial begin
    logic [31:0] held;
    logic hnx, hnv;
    void'($urandom(32'h5EED_0F17));
    repeat (3) @(negedge clk);
    check("R8", {out_int, out_inexact, out_invalid}, 34'd0);
    check("R8", {33'd0, out_valid}, 34'd0);
    rst_n = 1'b1;

    // Directed corners
    apply(3'd0, 1'b1, 20, 64'hFFFF_0000_0000_0001);          // R1 zero ignores fields
    apply(3'd1, 1'b0, 0, 64'h8000_0000_0000_0000);           // R3 exactly 1
    apply(3'd1, 1'b1, 0, 64'hC000_0000_0000_0000);           // R3/R4 -1, inexact
    apply(3'd1, 1'b0, -1, 64'h8000_0000_0000_0000);          // R4 0.5 -> 0, inexact
    apply(3'd1, 1'b1, -2048, 64'h8000_0000_0000_0000);       // R4 flushed shift
    apply(3'd1, 1'b1, 31, 64'h8000_0000_0000_0000);          // R5 accepted negative limit
    apply(3'd1, 1'b0, 31, 64'h8000_0000_0000_0000);          // R5 positive saturates
    apply(3'd1, 1'b1, 31, 64'h8000_0000_0000_0001);          // R5 limit with inexact
    apply(3'd1, 1'b0, 31, 64'hFFFF_FFFE_0000_0000);          // R5/R7
    apply(3'd1, 1'b0, 30, 64'hFFFF_FFFF_FFFF_FFFF);          // R3 max positive, inexact
    apply(3'd1, 1'b1, 32, 64'h8000_0000_0000_0000);          // R2
    apply(3'd1, 1'b0, 2047, 64'h8000_0000_0000_0000);        // R2
    apply(3'd2, 1'b0, 0, 64'h8000_0000_0000_0000);           // R6 infinity
    apply(3'd3, 1'b1, 5, 64'hC000_0000_0000_0000);           // R6 quiet NaN
    apply(3'd4, 1'b0, 5, 64'hA000_0000_0000_0000);           // R6 signalling NaN
    apply(3'd6, 1'b1, 1, 64'h8000_0000_0000_0000);           // R6 unused code

    // Idle hold (R8)
    held = out_int; hnx = out_inexact; hnv = out_invalid;
    in_class = 3'd1; in_sign = 1'b0; in_exp = 12'd3; in_mant = 64'hF000_0000_0000_0000;
    @(negedge clk);
    check("R8", {out_int, out_inexact, out_invalid}, {held, hnx, hnv});
    check("R8", {33'd0, out_valid}, 34'd0);

    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [2:0]  c;
      logic        s;
      int          e;
      logic [63:0] mt;
      int          pick;
      pick = $urandom_range(0, 19);
      if (pick == 0)       c = 3'd0;
      else if (pick < 15)  c = 3'd1;
      else                 c = 3'($urandom_range(2, 7));
      s  = 1'($urandom_range(0, 1));
      pick = $urandom_range(0, 15);
      if (pick == 0)       e = -2048 + $urandom_range(0, 100);
      else if (pick == 1)  e = 2047 - $urandom_range(0, 100);
      else                 e = $urandom_range(0, 80) - 40;
      mt = {1'b1, 31'($urandom), 32'($urandom)};
      if ($urandom_range(0, 2) == 0) mt = mt & ~((64'd1 << $urandom_range(0, 63)) - 64'd1);
      apply(c, s, e, mt);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule